// File: doc/BRIEF.md
# Coarse-Fine Regulator Mode Controller

This block is the digital decision core of a regulator that corrects its output with two switch arrays. One array holds large current units and one holds small current units. Both are driven as thermometer-coded enable vectors. In steady operation a fine loop nudges the small-unit array by one position each time the output comparator reports a finished comparison.

When a window detector reports the output outside its upper or lower bound, the controller takes over with the large-unit array. First it steps that array quickly, once per fast tick, for as long as the output keeps moving the wrong way. When a trend bit reports that the output has turned around, it switches to a slow tracking phase. In that phase it keeps stepping in the same direction, but only on slow ticks, until the output is back inside the window. It then returns control to the fine loop. This replaces a fixed guard interval after a large load change.

Everything runs on one system clock. The fast tick arrives as an enable input. The slow tick is derived inside the block: one slow tick for every `SLOW_DIV` fast ticks. A combined drive level, counted in small units, is also provided. One large unit counts as `UNIT_RATIO` small units.

Top module: `cfldo_mode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to fine mode (`mode` = 0), and both arrays are set to `W/2` units on, where W is the array width. The slow-tick divider also restarts.
- R2: In fine mode, each cycle with `cmp_done` high moves the fine count one position. It moves up when `cmp_below` is 1 and down when `cmp_below` is 0. Without `cmp_done`, the fine count holds.
- R3: In fine mode, a cycle with `fast_tick` high and `win_lo` high enters matching (`mode` = 1) with the direction set to raise. A cycle with `fast_tick` high, `win_hi` high and `win_lo` low enters matching with the direction set to lower. Without `fast_tick` the mode does not change.
- R4: In matching, each `fast_tick` cycle steps the coarse count by one unit in the stored direction, as long as `trend_up` has not reversed. Reversed means 1 when raising, or 0 when lowering.
- R5: In matching, a `fast_tick` cycle with a reversed `trend_up` moves to tracking (`mode` = 2). The coarse count does not step in that cycle.
- R6: In tracking, the coarse count steps one unit in the stored direction only on slow ticks. A slow tick is every `SLOW_DIV`-th fast tick, counted continuously since reset, and only while a window flag is still high.
- R7: In tracking, a `fast_tick` cycle with both `win_hi` and `win_lo` low returns to fine mode. The coarse count does not step in that cycle.
- R8: Both counts saturate: a step up at W units or a step down at 0 units leaves the count unchanged.
- R9: In matching and tracking, the fine count holds regardless of `cmp_done`. `trend_up` has no effect outside matching.
- R10: `mode` only takes the values 0, 1 and 2. `drive_units` equals the coarse count times `UNIT_RATIO`, plus the fine count.
- R11: Each enable vector is thermometer coded: with a count of k, bits 0 through k-1 are 1 and all higher bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fast_tick | input | 1 | Fast-rate enable pulse |
| cmp_done | input | 1 | Fine comparison finished strobe |
| cmp_below | input | 1 | Fine comparator result, 1 when output is below reference |
| win_hi | input | 1 | Output above the upper window bound |
| win_lo | input | 1 | Output below the lower window bound |
| trend_up | input | 1 | Output trend, 1 rising, 0 falling |
| mode | output | 2 | 0 fine, 1 matching, 2 tracking |
| coarse_en | output | COARSE_W | Thermometer enables of the large-unit array |
| fine_en | output | FINE_W | Thermometer enables of the small-unit array |
| drive_units | output | $clog2(COARSE_W*UNIT_RATIO+FINE_W+1) | Total drive in small units |

## Verification
The assertions check on every cycle the properties that do not depend on a scenario: the counts stay within range, move at most one step, and stay put without a tick. The fine count stays frozen outside fine mode. Tracking moves the coarse count only on slow ticks, and the mode never jumps straight from fine to tracking. The bench alone shows that whole sequences come out right: entry direction, the length of matching against a chosen trend pattern, the exact slow-tick phase across mode changes, and saturation over long runs. It compares every output in every cycle with an independent model.

// File: rtl/cfldo_pkg.sv
package cfldo_pkg;

    typedef enum logic [1:0] {
        MODE_FINE  = 2'd0,
        MODE_MATCH = 2'd1,
        MODE_TRACK = 2'd2
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  raise;
    } seq_state_t;

endpackage

// File: rtl/cfldo_tick_div.sv
module cfldo_tick_div #(
    parameter int SLOW_DIV = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic fast_tick,
    output logic slow_tick
);
    localparam int DW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(SLOW_DIV - 1);

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        slow_tick = fast_tick && (cnt_q == LAST);
        cnt_d     = cnt_q;
        if (fast_tick) begin
            cnt_d = slow_tick ? '0 : cnt_q + 1'b1;
        end
        if (rst) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    // R6: a slow tick is always also a fast tick
    a_r6_slow_in_fast: assert property (@(posedge clk) disable iff (rst)
        slow_tick |-> fast_tick);
    // R6: the phase counter stays below the division ratio
    a_r6_phase_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/cfldo_therm_ctr.sv
module cfldo_therm_ctr #(
    parameter int W = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_en,
    input  logic          step_up,
    output logic [CW-1:0] count,
    output logic [W-1:0]  therm
);
    localparam logic [CW-1:0] FULL = CW'(W);
    localparam logic [CW-1:0] MID  = CW'(W / 2);

    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (step_en) begin
            if (step_up && count_q != FULL) begin
                count_d = count_q + 1'b1;
            end else if (!step_up && count_q != '0) begin
                count_d = count_q - 1'b1;
            end
        end
        if (rst) begin
            count_d = MID;
        end
    end

    always_ff @(posedge clk) begin
        count_q <= count_d;
    end

    assign count = count_q;

    for (genvar i = 0; i < W; i++) begin : g_therm
        assign therm[i] = (count_q > CW'(i));
    end

    // R8: never above full scale
    a_r8_in_range: assert property (@(posedge clk) disable iff (rst)
        count_q <= FULL);
    // R8: stepping past the top is ignored
    a_r8_top_hold: assert property (@(posedge clk) disable iff (rst)
        (step_en && step_up && count_q == FULL) |=> count_q == FULL);
    // R8: stepping past the bottom is ignored
    a_r8_bottom_hold: assert property (@(posedge clk) disable iff (rst)
        (step_en && !step_up && count_q == '0) |=> count_q == '0);
    // R2: no step request, no movement
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(count_q));

endmodule

// File: rtl/cfldo_seq.sv
module cfldo_seq
    import cfldo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fast_tick,
    input  logic  slow_tick,
    input  logic  win_hi,
    input  logic  win_lo,
    input  logic  trend_up,
    output mode_e mode,
    output logic  coarse_step_en,
    output logic  coarse_step_up
);
    seq_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        coarse_step_en = 1'b0;
        if (fast_tick) begin
            case (st_q.mode)
                MODE_FINE: begin
                    if (win_lo) begin
                        st_d.mode  = MODE_MATCH;
                        st_d.raise = 1'b1;
                    end else if (win_hi) begin
                        st_d.mode  = MODE_MATCH;
                        st_d.raise = 1'b0;
                    end
                end
                MODE_MATCH: begin
                    if (trend_up == st_q.raise) begin
                        st_d.mode = MODE_TRACK;
                    end else begin
                        coarse_step_en = 1'b1;
                    end
                end
                MODE_TRACK: begin
                    if (!win_hi && !win_lo) begin
                        st_d.mode = MODE_FINE;
                    end else if (slow_tick) begin
                        coarse_step_en = 1'b1;
                    end
                end
                default: st_d.mode = MODE_FINE;
            endcase
        end
        if (rst) begin
            st_d.mode  = MODE_FINE;
            st_d.raise = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode           = st_q.mode;
    assign coarse_step_up = st_q.raise;

    // R10: only three encodings are ever used
    a_r10_mode_legal: assert property (@(posedge clk) disable iff (rst)
        st_q.mode != 2'd3);
    // R3: fine mode never jumps straight to tracking
    a_r3_no_skip: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_FINE) |=> (st_q.mode != MODE_TRACK));
    // R3: mode changes only on a fast tick
    a_r3_mode_on_tick: assert property (@(posedge clk) disable iff (rst)
        !fast_tick |=> $stable(st_q.mode));
    // R5: a reversed trend during matching leads to tracking
    a_r5_reverse: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_MATCH && fast_tick && trend_up == st_q.raise)
        |=> st_q.mode == MODE_TRACK);
    // R7: back inside the window ends tracking
    a_r7_exit: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_TRACK && fast_tick && !win_hi && !win_lo)
        |=> st_q.mode == MODE_FINE);
    // R9: direction is fixed while correcting
    a_r9_dir_fixed: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode != MODE_FINE) |=> $stable(st_q.raise));

endmodule

// File: rtl/cfldo_mode_ctrl.sv
module cfldo_mode_ctrl
    import cfldo_pkg::*;
#(
    parameter int FINE_W     = 16,
    parameter int COARSE_W   = 8,
    parameter int UNIT_RATIO = 4,
    parameter int SLOW_DIV   = 5,
    localparam int DRIVE_W   = $clog2(COARSE_W * UNIT_RATIO + FINE_W + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fast_tick,
    input  logic                cmp_done,
    input  logic                cmp_below,
    input  logic                win_hi,
    input  logic                win_lo,
    input  logic                trend_up,
    output logic [1:0]          mode,
    output logic [COARSE_W-1:0] coarse_en,
    output logic [FINE_W-1:0]   fine_en,
    output logic [DRIVE_W-1:0]  drive_units
);
    localparam int FCW = $clog2(FINE_W + 1);
    localparam int CCW = $clog2(COARSE_W + 1);

    logic           slow_tick;
    mode_e          mode_s;
    logic           c_step_en, c_step_up;
    logic           f_step_en;
    logic [FCW-1:0] fine_cnt;
    logic [CCW-1:0] coarse_cnt;

    cfldo_tick_div #(.SLOW_DIV(SLOW_DIV)) u_div (
        .clk       (clk),
        .rst       (rst),
        .fast_tick (fast_tick),
        .slow_tick (slow_tick)
    );

    cfldo_seq u_seq (
        .clk            (clk),
        .rst            (rst),
        .fast_tick      (fast_tick),
        .slow_tick      (slow_tick),
        .win_hi         (win_hi),
        .win_lo         (win_lo),
        .trend_up       (trend_up),
        .mode           (mode_s),
        .coarse_step_en (c_step_en),
        .coarse_step_up (c_step_up)
    );

    assign f_step_en = cmp_done && (mode_s == MODE_FINE);

    cfldo_therm_ctr #(.W(FINE_W)) u_fine (
        .clk     (clk),
        .rst     (rst),
        .step_en (f_step_en),
        .step_up (cmp_below),
        .count   (fine_cnt),
        .therm   (fine_en)
    );

    cfldo_therm_ctr #(.W(COARSE_W)) u_coarse (
        .clk     (clk),
        .rst     (rst),
        .step_en (c_step_en),
        .step_up (c_step_up),
        .count   (coarse_cnt),
        .therm   (coarse_en)
    );

    assign mode        = mode_s;
    assign drive_units = DRIVE_W'(coarse_cnt) * DRIVE_W'(UNIT_RATIO) + DRIVE_W'(fine_cnt);

    // R9: fine array frozen while a coarse sub-mode is active
    a_r9_fine_frozen: assert property (@(posedge clk) disable iff (rst)
        (mode_s != MODE_FINE) |=> $stable(fine_cnt));
    // R6: tracking moves the coarse array only on a slow tick
    a_r6_track_slow: assert property (@(posedge clk) disable iff (rst)
        (mode_s == MODE_TRACK && !slow_tick) |=> $stable(coarse_cnt));
    // R4: coarse array moves only on fast ticks
    a_r4_coarse_on_tick: assert property (@(posedge clk) disable iff (rst)
        !fast_tick |=> $stable(coarse_cnt));
    // R2: coarse array is idle during fine regulation
    a_r2_coarse_idle: assert property (@(posedge clk) disable iff (rst)
        (mode_s == MODE_FINE) |=> $stable(coarse_cnt));

endmodule

// File: tb/cfldo_mode_ctrl_test.sv
module cfldo_mode_ctrl_test;
    localparam int FW = 16;
    localparam int CW = 8;
    localparam int UR = 4;
    localparam int SD = 5;
    localparam int DW = $clog2(CW * UR + FW + 1);

    logic clk = 1'b0;
    logic rst, fast_tick, cmp_done, cmp_below, win_hi, win_lo, trend_up;
    logic [1:0]    mode;
    logic [CW-1:0] coarse_en;
    logic [FW-1:0] fine_en;
    logic [DW-1:0] drive_units;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    // model state
    int m_f, m_c, m_mode, m_raise, m_div;
    string rule;

    always #2 clk = ~clk;

    cfldo_mode_ctrl #(.FINE_W(FW), .COARSE_W(CW), .UNIT_RATIO(UR), .SLOW_DIV(SD)) uut (
        .clk(clk), .rst(rst), .fast_tick(fast_tick), .cmp_done(cmp_done),
        .cmp_below(cmp_below), .win_hi(win_hi), .win_lo(win_lo), .trend_up(trend_up),
        .mode(mode), .coarse_en(coarse_en), .fine_en(fine_en), .drive_units(drive_units)
    );

    function automatic int sat_step(int v, int up, int top);
        if (up != 0) return (v < top) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction

    function automatic logic [FW-1:0] therm_f(int n);
        logic [FW-1:0] v = '0;
        for (int i = 0; i < FW; i++) if (i < n) v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic [CW-1:0] therm_c(int n);
        logic [CW-1:0] v = '0;
        for (int i = 0; i < CW; i++) if (i < n) v[i] = 1'b1;
        return v;
    endfunction

    task automatic model_step();
        int slow;
        if (rst) begin
            m_f = FW / 2; m_c = CW / 2; m_mode = 0; m_raise = 0; m_div = 0;
            rule = "R1";
            return;
        end
        slow = (fast_tick && m_div == SD - 1) ? 1 : 0;
        if (fast_tick) m_div = (slow != 0) ? 0 : m_div + 1;
        case (m_mode)
            0: begin
                rule = "R2";
                if (cmp_done) begin
                    if ((cmp_below && m_f == FW) || (!cmp_below && m_f == 0)) rule = "R8";
                    m_f = sat_step(m_f, cmp_below, FW);
                end
                if (fast_tick && win_lo) begin m_mode = 1; m_raise = 1; rule = "R3"; end
                else if (fast_tick && win_hi) begin m_mode = 1; m_raise = 0; rule = "R3"; end
            end
            1: begin
                rule = "R9";
                if (fast_tick) begin
                    if (trend_up == m_raise[0]) begin m_mode = 2; rule = "R5"; end
                    else begin
                        rule = ((m_raise != 0 && m_c == CW) || (m_raise == 0 && m_c == 0)) ? "R8" : "R4";
                        m_c = sat_step(m_c, m_raise, CW);
                    end
                end
            end
            default: begin
                rule = "R9";
                if (fast_tick) begin
                    if (!win_hi && !win_lo) begin m_mode = 0; rule = "R7"; end
                    else begin
                        rule = "R6";
                        if (slow != 0) m_c = sat_step(m_c, m_raise, CW);
                    end
                end
            end
        endcase
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(logic r, logic ft, logic dn, logic bl, logic hi, logic lo, logic tr);
        rst = r; fast_tick = ft; cmp_done = dn; cmp_below = bl;
        win_hi = hi; win_lo = lo; trend_up = tr;
        model_step();
        @(negedge clk);
        chk({rule, " mode"}, int'(mode), m_mode);
        chk({rule, " fine_en R11"}, int'(fine_en), int'(therm_f(m_f)));
        chk({rule, " coarse_en R11"}, int'(coarse_en), int'(therm_c(m_c)));
        chk("R10 drive_units", int'(drive_units), m_c * UR + m_f);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state
        repeat (3) cyc(1, 0, 0, 0, 0, 0, 0);
        // R2/R8: fine up to saturation, then down to saturation
        repeat (FW + 3) cyc(0, 0, 1, 1, 0, 0, 0);
        repeat (FW + 3) cyc(0, 0, 1, 0, 0, 0, 0);
        // R3: window flag without fast tick does nothing
        repeat (3) cyc(0, 0, 0, 0, 0, 1, 0);
        // R3/R4/R8: undershoot matching to coarse saturation
        repeat (CW + 4) cyc(0, 1, 0, 0, 0, 1, 0);
        // R5: trend reverses, R6/R9: tracking with strobes ignored
        cyc(0, 1, 0, 0, 0, 1, 1);
        repeat (12) cyc(0, 1, 1, 1, 0, 1, 0);
        // R7: back inside window
        cyc(0, 1, 0, 0, 0, 0, 0);
        // overshoot mirror, with gaps in the fast tick
        for (int i = 0; i < 2 * CW + 6; i++) cyc(0, i[0], 0, 0, 1, 0, 1);
        cyc(0, 1, 0, 0, 1, 0, 0);
        for (int i = 0; i < 15; i++) cyc(0, 1, 0, 0, 1, 0, i[1]);
        cyc(0, 1, 0, 0, 0, 0, 1);
        // both flags at once: lower bound wins (R3)
        cyc(0, 1, 0, 0, 1, 1, 0);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic r, ft, dn, bl, hi, lo, tr;
            r  = ($urandom % 600) == 0;
            ft = ($urandom % 3) != 0;
            dn = ($urandom % 3) == 0;
            bl = $urandom % 2;
            lo = ($urandom % 6) == 0;
            hi = !lo && (($urandom % 6) == 0);
            tr = ($urandom % 4) == 0 ? ~m_raise[0] : m_raise[0];
            cyc(r, ft, dn, bl, hi, lo, tr);
        end
        done_flag = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule